// File: doc/BRIEF.md
# Vector-Priority Interrupt Controller

This block collects interrupt requests, each carrying an 8-bit vector, and decides which one the processor should take next. The vector number itself is the priority. Its upper four bits form a priority class and its lower four bits rank vectors inside that class, so a numerically larger vector always wins. Pending requests live in a 256-bit request set and vectors being serviced live in a 256-bit service set.

Delivery is gated by a processor priority. This is the larger of a software-written task priority and the class of the highest vector in service. A pending vector is offered on the level-style `intr` output only when its class is strictly above the processor priority class. Otherwise it waits in the request set until the gate opens.

The processor takes an offered vector by pulsing `inta`. It ends service by pulsing `eoi`, which retires the highest vector in service.

Top module: `vpic_ctrl`

## Requirements
- R1: The class of a vector is bits [7:4]. Delivery compares only class values, so the low nibble of the task priority never changes whether a vector is offered.
- R2: Of all pending vectors, the numerically largest is the one offered and acknowledged. This applies both inside a class and across classes.
- R3: A request with vector below 16 changes no pending state. It raises `err_illegal` for exactly the one cycle after the clock edge that samples it.
- R4: `ppr_out` equals the task priority when no vector is in service, or when the task class is at least the class of the highest in-service vector. Otherwise `ppr_out` is {that class, 4'h0}.
- R5: `intr` is 1 exactly when the highest pending vector's class is greater than `ppr_out[7:4]`. A pending vector that is held back stays pending and is delivered once the gate opens.
- R6: `inta` sampled while `intr` is 1 clears the offered vector's request bit and sets its service bit. It also drives `ack_valid` high for one cycle after that edge, with the vector on `ack_vector`. `inta` while `intr` is 0 is ignored.
- R7: `eoi` clears the highest set service bit at its clock edge, and `ppr_out` and `intr` reflect the change right after that edge.
- R8: A task priority write (`tpr_we`) takes effect on `ppr_out` and `intr` right after the edge that samples it.
- R9: Repeated requests for a vector that is already pending merge into one request bit and yield one acknowledge.
- R10: After reset, no vector is pending or in service, the task priority is 0, and `intr`, `ack_valid` and `err_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| eoi | input | 1 | End-of-interrupt strobe |
| inta | input | 1 | Interrupt acknowledge strobe |
| intr | output | 1 | A deliverable vector is pending |
| ack_valid | output | 1 | Acknowledged vector is on `ack_vector` |
| ack_vector | output | 8 | Vector taken by the last acknowledge |
| ppr_out | output | 8 | Current processor priority |
| err_illegal | output | 1 | Reserved-range request was seen |

## Verification
Every stimulus is applied at a falling edge, and its effect is due after the next rising edge. `ack_valid`, `ack_vector` and `err_illegal` are registered one edge after their strobe. `intr` and `ppr_out` follow combinationally from the request, service and task registers written at that same edge. The bench therefore compares all outputs at the following falling edge against a model that steps once per cycle, and it treats a pre-edge model state as the basis for that cycle's acknowledge and end-of-interrupt.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   typedef enum logic {
      PPR_FROM_TASK    = 1'b0,
      PPR_FROM_SERVICE = 1'b1
   } ppr_src_e;
endpackage

// File: rtl/vpic_top_finder.sv
module vpic_top_finder #(
   parameter int N     = 256,
   parameter int IDX_W = 8
) (
   input  logic [N-1:0]     bits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   initial begin
      if (N > (1 << IDX_W)) $fatal(1, "vpic_top_finder: IDX_W too narrow");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (bits[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vpic_prio_calc.sv
module vpic_prio_calc
   import vpic_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int CLASS_W = 4
) (
   input  logic [VEC_W-1:0] task_prio,
   input  logic             svc_any,
   input  logic [VEC_W-1:0] svc_top,
   output logic [VEC_W-1:0] proc_prio,
   output ppr_src_e         src
);
   localparam int FINE_W = VEC_W - CLASS_W;

   logic [CLASS_W-1:0] task_cls;
   logic [CLASS_W-1:0] svc_cls;

   assign task_cls = task_prio[VEC_W-1 -: CLASS_W];
   assign svc_cls  = svc_top[VEC_W-1 -: CLASS_W];

   always_comb begin
      if (svc_any && (svc_cls > task_cls)) begin
         src       = PPR_FROM_SERVICE;
         proc_prio = {svc_cls, {FINE_W{1'b0}}};
      end else begin
         src       = PPR_FROM_TASK;
         proc_prio = task_prio;
      end
   end
endmodule

// File: rtl/vpic_vec_bank.sv
module vpic_vec_bank #(
   parameter int VEC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_set,
   input  logic [VEC_W-1:0]        req_idx,
   input  logic                    ack_fire,
   input  logic [VEC_W-1:0]        ack_idx,
   input  logic                    eoi_fire,
   input  logic [VEC_W-1:0]        eoi_idx,
   output logic [(1<<VEC_W)-1:0]   pend_q,
   output logic [(1<<VEC_W)-1:0]   svc_q
);
   localparam int N = 1 << VEC_W;

   for (genvar v = 0; v < N; v++) begin : g_bit
      logic hit_req;
      logic hit_ack;
      logic hit_eoi;

      assign hit_req = req_set  && (req_idx == VEC_W'(v));
      assign hit_ack = ack_fire && (ack_idx == VEC_W'(v));
      assign hit_eoi = eoi_fire && (eoi_idx == VEC_W'(v));

      always_ff @(posedge clk) begin
         if (!rst_n)       pend_q[v] <= 1'b0;
         else if (hit_req) pend_q[v] <= 1'b1;
         else if (hit_ack) pend_q[v] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)       svc_q[v] <= 1'b0;
         else if (hit_ack) svc_q[v] <= 1'b1;
         else if (hit_eoi) svc_q[v] <= 1'b0;
      end
   end
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
   import vpic_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int CLASS_W = 4,
   parameter int RSV_LO  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vector,
   input  logic             tpr_we,
   input  logic [VEC_W-1:0] tpr_wdata,
   input  logic             eoi,
   input  logic             inta,
   output logic             intr,
   output logic             ack_valid,
   output logic [VEC_W-1:0] ack_vector,
   output logic [VEC_W-1:0] ppr_out,
   output logic             err_illegal
);
   localparam int N = 1 << VEC_W;

   initial begin
      if (CLASS_W < 1 || CLASS_W >= VEC_W) $fatal(1, "vpic_ctrl: bad CLASS_W");
      if (RSV_LO < 0 || RSV_LO > N)        $fatal(1, "vpic_ctrl: bad RSV_LO");
   end

   logic [N-1:0]       irr_q;
   logic [N-1:0]       isr_q;
   logic [VEC_W-1:0]   tpr_q;
   logic               irr_any;
   logic [VEC_W-1:0]   irr_top;
   logic               isr_any;
   logic [VEC_W-1:0]   isr_top;
   ppr_src_e           ppr_src;
   logic               req_ok;
   logic               req_bad;
   logic               ack_fire;

   vpic_top_finder #(.N(N), .IDX_W(VEC_W)) u_irr_find (
      .bits(irr_q), .any(irr_any), .idx(irr_top)
   );

   vpic_top_finder #(.N(N), .IDX_W(VEC_W)) u_isr_find (
      .bits(isr_q), .any(isr_any), .idx(isr_top)
   );

   vpic_prio_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
      .task_prio(tpr_q), .svc_any(isr_any), .svc_top(isr_top),
      .proc_prio(ppr_out), .src(ppr_src)
   );

   assign req_bad  = req_valid && (int'(req_vector) < RSV_LO);
   assign req_ok   = req_valid && !req_bad;
   assign intr     = irr_any &&
                     (irr_top[VEC_W-1 -: CLASS_W] > ppr_out[VEC_W-1 -: CLASS_W]);
   assign ack_fire = inta && intr;

   vpic_vec_bank #(.VEC_W(VEC_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .req_set(req_ok), .req_idx(req_vector),
      .ack_fire(ack_fire), .ack_idx(irr_top),
      .eoi_fire(eoi && isr_any), .eoi_idx(isr_top),
      .pend_q(irr_q), .svc_q(isr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q       <= '0;
         ack_valid   <= 1'b0;
         ack_vector  <= '0;
         err_illegal <= 1'b0;
      end else begin
         if (tpr_we) tpr_q <= tpr_wdata;
         ack_valid   <= ack_fire;
         if (ack_fire) ack_vector <= irr_top;
         err_illegal <= req_bad;
      end
   end
endmodule

// File: rtl/vpic_ctrl_chk.sv
module vpic_ctrl_chk #(
   parameter int VEC_W   = 8,
   parameter int CLASS_W = 4,
   parameter int RSV_LO  = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [VEC_W-1:0]      req_vector,
   input logic                  inta,
   input logic                  eoi,
   input logic                  intr,
   input logic                  ack_valid,
   input logic [VEC_W-1:0]      ack_vector,
   input logic [VEC_W-1:0]      ppr_out,
   input logic                  err_illegal,
   input logic [VEC_W-1:0]      tpr_q,
   input logic [(1<<VEC_W)-1:0] isr_q,
   input logic                  isr_any
);
   localparam int HI = VEC_W - 1;

   AST_ACK_NEEDS_INTA: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(inta && intr)); // R6

   AST_ACK_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (ack_vector[HI -: CLASS_W] > $past(ppr_out[HI -: CLASS_W]))); // R5

   AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> isr_q[ack_vector]); // R6

   AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      err_illegal |-> $past(req_valid && (int'(req_vector) < RSV_LO))); // R3

   AST_PPR_NOT_BELOW_TASK: assert property (@(posedge clk) disable iff (!rst_n)
      ppr_out[HI -: CLASS_W] >= tpr_q[HI -: CLASS_W]); // R4

   AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !(inta && intr)) |=>
         ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R7
endmodule

bind vpic_ctrl vpic_ctrl_chk #(.VEC_W(VEC_W), .CLASS_W(CLASS_W), .RSV_LO(RSV_LO)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
   .inta(inta), .eoi(eoi), .intr(intr), .ack_valid(ack_valid),
   .ack_vector(ack_vector), .ppr_out(ppr_out), .err_illegal(err_illegal),
   .tpr_q(tpr_q), .isr_q(isr_q), .isr_any(isr_any)
);

// File: tb/vpic_ctrl_bench.sv
`timescale 1ns/1ps
module vpic_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid, tpr_we, eoi, inta;
   logic [7:0] req_vector, tpr_wdata;
   logic       intr, ack_valid, err_illegal;
   logic [7:0] ack_vector, ppr_out;

   int checks = 0;
   int errors = 0;
   logic [255:0] irr_m, isr_m;
   logic [7:0]   tpr_m;

   always #4 clk = ~clk;

   vpic_ctrl u_vpic_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .eoi(eoi), .inta(inta),
      .intr(intr), .ack_valid(ack_valid), .ack_vector(ack_vector),
      .ppr_out(ppr_out), .err_illegal(err_illegal)
   );

   function automatic int top_of(input logic [255:0] b);
      int r = -1;
      for (int i = 0; i < 256; i++) if (b[i]) r = i;
      return r;
   endfunction

   function automatic int ppr_of(input logic [255:0] s, input logic [7:0] t);
      int si = top_of(s);
      if (si >= 0 && (si >> 4) > int'(t[7:4])) return (si >> 4) << 4;
      return int'(t);
   endfunction

   function automatic bit intr_of(input logic [255:0] p, input logic [255:0] s,
                                  input logic [7:0] t);
      int pi = top_of(p);
      return (pi >= 0) && ((pi >> 4) > (ppr_of(s, t) >> 4));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, model the edge, compare at next falling edge
   task automatic step(input bit rv, input int rvec, input bit ia, input bit eo,
                       input bit tw, input int td);
      int  ti, si;
      bit  ack_m, err_m;
      ti = top_of(irr_m);
      si = top_of(isr_m);
      ack_m = ia && intr_of(irr_m, isr_m, tpr_m);
      err_m = rv && (rvec < 16);
      req_valid = rv; req_vector = 8'(rvec); inta = ia; eoi = eo;
      tpr_we = tw; tpr_wdata = 8'(td);
      if (eo && si >= 0) isr_m[si] = 1'b0;
      if (ack_m) begin irr_m[ti] = 1'b0; isr_m[ti] = 1'b1; end
      if (rv && rvec >= 16) irr_m[rvec] = 1'b1;
      if (tw) tpr_m = 8'(td);
      @(negedge clk);
      req_valid = 0; inta = 0; eoi = 0; tpr_we = 0;
      chk(ack_valid == ack_m, "R6 ack_valid", ack_valid, ack_m);
      if (ack_m) chk(ack_vector == 8'(ti), "R2 ack_vector", ack_vector, ti);
      chk(err_illegal == err_m, "R3 err_illegal", err_illegal, err_m);
      chk(int'(ppr_out) == ppr_of(isr_m, tpr_m), "R4 ppr_out", ppr_out, ppr_of(isr_m, tpr_m));
      chk(intr == intr_of(irr_m, isr_m, tpr_m), "R5 intr", intr, intr_of(irr_m, isr_m, tpr_m));
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      irr_m = '0; isr_m = '0; tpr_m = '0;
      rst_n = 0; req_valid = 0; req_vector = 0; tpr_we = 0; tpr_wdata = 0;
      eoi = 0; inta = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(intr == 0 && ack_valid == 0 && err_illegal == 0, "R10 outputs", intr, 0);
      chk(ppr_out == 8'h00, "R10 ppr", ppr_out, 0);

      // R2 ordering within and across classes
      step(1, 'h41, 0, 0, 0, 0);
      step(1, 'h4F, 0, 0, 0, 0);
      step(1, 'h39, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      chk(ack_vector == 8'h4F, "R2 largest first", ack_vector, 'h4F);
      // R5 0x41 held: same class as in-service 0x4F
      chk(intr == 0, "R5 held same class", intr, 0);
      step(0, 0, 1, 0, 0, 0);
      chk(ack_valid == 0, "R6 inta ignored when intr low", ack_valid, 0);
      // R7 eoi opens the gate
      step(0, 0, 0, 1, 0, 0);
      chk(intr == 1 && ppr_out == 8'h00, "R7 eoi releases", intr, 1);
      step(0, 0, 1, 0, 0, 0);
      chk(ack_vector == 8'h41, "R5 held vector delivered later", ack_vector, 'h41);
      step(0, 0, 0, 1, 0, 0);
      // R3 illegal vector
      step(1, 'h0A, 0, 0, 0, 0);
      chk(err_illegal == 1, "R3 flag", err_illegal, 1);
      step(0, 0, 0, 0, 0, 0);
      chk(err_illegal == 0, "R3 one cycle", err_illegal, 0);
      step(0, 0, 1, 0, 0, 0);
      chk(ack_vector == 8'h39, "R3 no pending 0x0A", ack_vector, 'h39);
      step(0, 0, 0, 1, 0, 0);
      chk(intr == 0, "R3 nothing pending", intr, 0);
      // R8 / R1 task priority gating uses class only
      step(0, 0, 0, 0, 1, 'h50);
      step(1, 'h51, 0, 0, 0, 0);
      chk(intr == 0, "R8 class equal held", intr, 0);
      step(0, 0, 0, 0, 1, 'h4F);
      chk(intr == 1 && ppr_out == 8'h4F, "R1 low nibble ignored", intr, 1);
      step(0, 0, 1, 0, 1, 'h00);
      step(0, 0, 0, 1, 0, 0);
      // R9 duplicate merge
      step(1, 'h80, 0, 0, 0, 0);
      step(1, 'h80, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      chk(ack_vector == 8'h80, "R9 ack", ack_vector, 'h80);
      step(0, 0, 0, 1, 0, 0);
      chk(intr == 0, "R9 single request", intr, 0);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         bit rv = ($urandom_range(0, 3) == 0);
         int rvec = $urandom_range(0, 255);
         bit ia = ($urandom_range(0, 2) == 0);
         bit eo = ($urandom_range(0, 5) == 0);
         bit tw = ($urandom_range(0, 40) == 0);
         int td = $urandom_range(0, 200);
         step(rv, rvec, ia, eo, tw, td);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule